// File: doc/BRIEF.md
# Coil PWM Current Regulator with Automatic Decay Selection

This block is the digital control loop for one coil of a two-phase stepper bridge. It runs on the oscillator clock and splits time into fixed PWM periods. At the start of each period it drives the coil forward in the polarity given by the sign of the requested current. It watches a single comparator bit that is high when the measured winding current is at or above the requested magnitude. When that bit goes high, it switches to slow decay, with both low-side switches on, for the rest of the period.

If the requested magnitude drops, the block reverses the bridge and applies fast decay at once. Fast decay continues, across period boundaries if needed, until the comparator reports that the current is below the new target. A gate stage at the output puts a dead time of a fixed number of ticks in front of every switch turn-on. This keeps the high-side and low-side switches of the same half-bridge from conducting together. Configuration inputs halve the period and add a pseudo-random extension to each period. A motor-enable input turns all four gates off.

Top module: `coil_pwm_regulator`

## Requirements
- R1: While reset is asserted, and after it is released with the motor enable low, all four gate outputs are 0.
- R2: When the motor enable is sampled low at a clock edge, all four gates are 0 after that edge and stay 0 while the enable stays low.
- R3: With period halving and jitter both off, a PWM period lasts exactly 175 clock ticks.
- R4: With period halving on and jitter off, a PWM period lasts exactly 88 clock ticks.
- R5: With jitter on, each period is extended by 0 to 17 ticks (175..192, or 88..105 when halved), and the extension varies from period to period.
- R6: Each period starts in forward drive. For sign 0, forward drive is high-side A plus low-side B. For sign 1, it is high-side B plus low-side A.
- R7: In forward drive, a comparator value of 1 (measured current >= target) switches the bridge to slow decay, with low-side A and low-side B on and both high sides off, until the next period starts.
- R8: While the target magnitude stays the same or increases, fast decay is never applied, whatever the comparator does.
- R9: A drop of the target magnitude starts fast decay at once: the reverse of forward drive for the current sign (sign 0: high-side B plus low-side A). Fast decay persists across period starts while the comparator stays 1.
- R10: Fast decay ends when the comparator reads 0. The bridge then goes to slow decay, and returns to forward drive at the next period start (or directly to forward drive if that tick is a period start).
- R11: High-side A and low-side A are never on together; the same holds for high-side B and low-side B.
- R12: A gate turns on only after the four-gate vector has been unchanged for at least DEAD_TICKS (default 4) cycles, including on polarity reversal and on fast-decay entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator tick clock |
| rstN | input | 1 | Active-low synchronous reset |
| motEn | input | 1 | Motor enable; 0 forces all gates off |
| dblFreq | input | 1 | 1 halves the PWM period |
| jitterEn | input | 1 | 1 adds a pseudo-random extension to each period |
| tgtMag | input | MAG_W (5) | Requested current magnitude |
| tgtSign | input | 1 | Requested current polarity |
| cmpHigh | input | 1 | 1 when measured current >= requested current |
| gateHiA | output | 1 | High-side switch, half-bridge A |
| gateLoA | output | 1 | Low-side switch, half-bridge A |
| gateHiB | output | 1 | High-side switch, half-bridge B |
| gateLoB | output | 1 | Low-side switch, half-bridge B |

## Verification
Period length is measured from the falling edge of low-side A that repeats once per period when the comparator is held high. This covers the plain, halved and jittered cases and their combinations. The jittered runs must land inside the allowed window and must not repeat one value. Directed sequences check the main loop: forward, slow and fast decay appear only under their own conditions. These sequences contrast a falling target with a rising one and a comparator held high with one released. Polarity flips and enable drops show the interlock and the shut-off. A random phase with a fixed seed toggles the comparator freely under non-decreasing targets; any fast-decay pattern in that phase separates a correct decay selector from one that reacts to the comparator alone.

// File: rtl/coil_pwm_pkg.sv
package coil_pwm_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_FWD  = 2'd1,
    MODE_SLOW = 2'd2,
    MODE_FAST = 2'd3
  } decayMode_e;

  // gate vector order: {hiA, loA, hiB, loB}
  localparam int G_HI_A = 3;
  localparam int G_LO_A = 2;
  localparam int G_HI_B = 1;
  localparam int G_LO_B = 0;

  typedef struct packed {
    logic       run;
    logic [3:0] gateReq;
  } ctrlStrobes_t;

endpackage

// File: rtl/coil_pwm_decay_ctrl.sv
module coil_pwm_decay_ctrl
  import coil_pwm_pkg::*;
#(
  parameter int MAG_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             motEn,
  input  logic [MAG_W-1:0] tgtMag,
  input  logic             tgtSign,
  input  logic             cmpHigh,
  input  logic             periodStart,
  output ctrlStrobes_t     strb
);

  decayMode_e       mode;
  logic [MAG_W-1:0] prevMag;
  logic             magDrop;

  assign magDrop = (tgtMag < prevMag);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode    <= MODE_OFF;
      prevMag <= '0;
    end else begin
      prevMag <= tgtMag;
      if (!motEn) begin
        mode <= MODE_OFF;
      end else if (magDrop) begin
        mode <= MODE_FAST;
      end else begin
        unique case (mode)
          MODE_OFF:  if (periodStart) mode <= MODE_FWD;
          MODE_FWD:  if (!periodStart && cmpHigh) mode <= MODE_SLOW;
          MODE_SLOW: if (periodStart) mode <= MODE_FWD;
          MODE_FAST: if (!cmpHigh) mode <= periodStart ? MODE_FWD : MODE_SLOW;
          default:   mode <= MODE_OFF;
        endcase
      end
    end
  end

  logic [3:0] fwdPat;
  logic [3:0] revPat;

  assign fwdPat = tgtSign ? 4'b0110 : 4'b1001;
  assign revPat = tgtSign ? 4'b1001 : 4'b0110;

  always_comb begin
    strb.run     = motEn;
    strb.gateReq = 4'b0000;
    if (motEn) begin
      unique case (mode)
        MODE_FWD:  strb.gateReq = fwdPat;
        MODE_SLOW: strb.gateReq = 4'b0101;
        MODE_FAST: strb.gateReq = revPat;
        default:   strb.gateReq = 4'b0000;
      endcase
    end
  end

endmodule

// File: rtl/coil_pwm_datapath.sv
module coil_pwm_datapath
  import coil_pwm_pkg::*;
#(
  parameter int BASE_TICKS = 175,
  parameter int JIT_SPAN   = 18,
  parameter int DEAD_TICKS = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strb,
  input  logic         dblFreq,
  input  logic         jitterEn,
  output logic         periodStart,
  output logic [3:0]   gates
);

  localparam int DBL_TICKS = (BASE_TICKS + 1) / 2;
  localparam int MAX_TICKS = BASE_TICKS + JIT_SPAN - 1;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);
  localparam int OFF_W     = $clog2(JIT_SPAN);
  localparam int DEAD_W    = $clog2(DEAD_TICKS + 1);
  localparam int LFSR_W    = 8;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 8'hA5;

  // ---------------- period timer with jitter ----------------
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  curLen;
  logic [CNT_W-1:0]  nextLen;
  logic [CNT_W-1:0]  baseLen;
  logic [LFSR_W-1:0] lfsr;
  logic [LFSR_W-1:0] lfsrNext;
  logic [OFF_W-1:0]  jitRaw;
  logic [OFF_W-1:0]  jitOff;

  assign lfsrNext = {lfsr[LFSR_W-2:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  assign jitRaw   = lfsr[OFF_W-1:0];
  assign jitOff   = (int'(jitRaw) >= JIT_SPAN) ? OFF_W'(int'(jitRaw) - JIT_SPAN) : jitRaw;
  assign baseLen  = dblFreq ? CNT_W'(DBL_TICKS) : CNT_W'(BASE_TICKS);
  assign nextLen  = baseLen + (jitterEn ? CNT_W'(jitOff) : CNT_W'(0));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      curLen <= CNT_W'(BASE_TICKS);
      lfsr   <= LFSR_SEED;
    end else if (!strb.run) begin
      cnt    <= '0;
      curLen <= nextLen;
    end else if (cnt == curLen - CNT_W'(1)) begin
      cnt    <= '0;
      curLen <= nextLen;
      lfsr   <= lfsrNext;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign periodStart = strb.run && (cnt == '0);

  // ---------------- dead-time gate stage ----------------
  logic [DEAD_W-1:0] deadCnt;
  logic [3:0]        excess;

  assign excess = gates & ~strb.gateReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gates   <= 4'b0000;
      deadCnt <= '0;
    end else if (gates == strb.gateReq) begin
      deadCnt <= '0;
    end else if (excess != 4'b0000) begin
      gates   <= gates & strb.gateReq;
      deadCnt <= '0;
    end else if (deadCnt == DEAD_W'(DEAD_TICKS - 1)) begin
      gates   <= strb.gateReq;
      deadCnt <= '0;
    end else begin
      deadCnt <= deadCnt + DEAD_W'(1);
    end
  end

endmodule

// File: rtl/coil_pwm_regulator.sv
module coil_pwm_regulator
  import coil_pwm_pkg::*;
#(
  parameter int MAG_W      = 5,
  parameter int BASE_TICKS = 175,
  parameter int JIT_SPAN   = 18,
  parameter int DEAD_TICKS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             motEn,
  input  logic             dblFreq,
  input  logic             jitterEn,
  input  logic [MAG_W-1:0] tgtMag,
  input  logic             tgtSign,
  input  logic             cmpHigh,
  output logic             gateHiA,
  output logic             gateLoA,
  output logic             gateHiB,
  output logic             gateLoB
);

  ctrlStrobes_t strb;
  logic         periodStart;
  logic [3:0]   gates;

  coil_pwm_decay_ctrl #(.MAG_W(MAG_W)) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .motEn       (motEn),
    .tgtMag      (tgtMag),
    .tgtSign     (tgtSign),
    .cmpHigh     (cmpHigh),
    .periodStart (periodStart),
    .strb        (strb)
  );

  coil_pwm_datapath #(
    .BASE_TICKS (BASE_TICKS),
    .JIT_SPAN   (JIT_SPAN),
    .DEAD_TICKS (DEAD_TICKS)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .dblFreq     (dblFreq),
    .jitterEn    (jitterEn),
    .periodStart (periodStart),
    .gates       (gates)
  );

  assign gateHiA = gates[G_HI_A];
  assign gateLoA = gates[G_LO_A];
  assign gateHiB = gates[G_HI_B];
  assign gateLoB = gates[G_LO_B];

endmodule

// File: rtl/coil_pwm_regulator_chk.sv
module coil_pwm_regulator_chk #(
  parameter int DEAD_TICKS = 4
) (
  input logic clk,
  input logic rstN,
  input logic motEn,
  input logic gateHiA,
  input logic gateLoA,
  input logic gateHiB,
  input logic gateLoB
);

  localparam int SC_W = $clog2(DEAD_TICKS + 1) + 1;

  logic [3:0]      gv;
  logic [3:0]      prevGv;
  logic [SC_W-1:0] stableCnt;

  assign gv = {gateHiA, gateLoA, gateHiB, gateLoB};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevGv    <= 4'b0000;
      stableCnt <= SC_W'(DEAD_TICKS);
    end else begin
      prevGv <= gv;
      if (gv != prevGv) stableCnt <= SC_W'(1);
      else if (stableCnt < SC_W'(DEAD_TICKS)) stableCnt <= stableCnt + SC_W'(1);
    end
  end

  AST_HALF_A_EXCL: assert property (@(posedge clk) disable iff (!rstN) !(gateHiA && gateLoA)); // R11
  AST_HALF_B_EXCL: assert property (@(posedge clk) disable iff (!rstN) !(gateHiB && gateLoB)); // R11
  AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rstN) !motEn |=> (gv == 4'b0000)); // R2
  AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rstN) ((gv & ~prevGv) != 4'b0000) |-> (stableCnt >= SC_W'(DEAD_TICKS))); // R12

endmodule

bind coil_pwm_regulator coil_pwm_regulator_chk #(.DEAD_TICKS(DEAD_TICKS)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .motEn   (motEn),
  .gateHiA (gateHiA),
  .gateLoA (gateLoA),
  .gateHiB (gateHiB),
  .gateLoB (gateLoB)
);

// File: tb/coil_pwm_regulator_tb_top.sv
module coil_pwm_regulator_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEAD       = 4;
  localparam int BASE       = 175;
  localparam int DBL        = 88;
  localparam int JMAX       = 17;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       motEn = 1'b0;
  logic       dblFreq = 1'b0;
  logic       jitterEn = 1'b0;
  logic [4:0] tgtMag = 5'd0;
  logic       tgtSign = 1'b0;
  logic       cmpHigh = 1'b0;
  logic       gateHiA, gateLoA, gateHiB, gateLoB;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;
  longint cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  coil_pwm_regulator dut_i (
    .clk(clk), .rstN(rstN), .motEn(motEn), .dblFreq(dblFreq), .jitterEn(jitterEn),
    .tgtMag(tgtMag), .tgtSign(tgtSign), .cmpHigh(cmpHigh),
    .gateHiA(gateHiA), .gateLoA(gateLoA), .gateHiB(gateHiB), .gateLoB(gateLoB)
  );

  function automatic logic [3:0] fwdPat(input logic s);
    return s ? 4'b0110 : 4'b1001;
  endfunction
  function automatic logic [3:0] fastPat(input logic s);
    return s ? 4'b1001 : 4'b0110;
  endfunction
  function automatic logic [3:0] slowPat();
    return 4'b0101;
  endfunction

  function automatic logic [3:0] gv();
    return {gateHiA, gateLoA, gateHiB, gateLoB};
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chkRange(input string req, input longint act, input longint lo, input longint hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // time of next falling edge of low-side A
  task automatic waitLoAFall(output longint t);
    logic p;
    p = gateLoA;
    forever begin
      @(negedge clk);
      if (p && !gateLoA) break;
      p = gateLoA;
    end
    t = cyc;
  endtask

  task automatic measure(input string req, input int n, input int lo, input int hi);
    longint t0, t1;
    int first;
    bit varied;
    varied = 1'b0;
    first = 0;
    waitLoAFall(t0);
    for (int i = 0; i < n; i++) begin
      waitLoAFall(t1);
      chkRange(req, t1 - t0, lo, hi);
      if (i == 0) first = int'(t1 - t0);
      else if (int'(t1 - t0) != first) varied = 1'b1;
      t0 = t1;
    end
    if (lo != hi) chk({req, " varies"}, varied, 1);
  endtask

  // interlock and dead-time monitor: R11, R12
  logic [3:0] monPrev = 4'b0000;
  int monStable = 100;
  always @(negedge clk) begin
    if (rstN) begin
      if ((gateHiA && gateLoA) || (gateHiB && gateLoB)) begin
        total++; bad++;
        $display("FAIL R11 actual=%b expected=no shoot-through", gv());
      end
      if (gv() != monPrev) begin
        if ((gv() & ~monPrev) != 4'b0000) chkRange("R12 dead gap", monStable, DEAD, 1000000);
        monStable = 1;
      end else if (monStable < 1000000) begin
        monStable++;
      end
      monPrev = gv();
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int r;
    r = $urandom(32'd4711);
    tick(5);
    chk("R1 gates in reset", gv(), 0);
    rstN = 1'b1;
    tick(20);
    chk("R1 gates after reset, enable low", gv(), 0);
    chk("R2 disabled stays off", gv(), 0);

    // R6 forward at period start, sign 0
    tgtMag = 5'd20; motEn = 1'b1;
    tick(20);
    chk("R6 forward sign0", gv(), fwdPat(1'b0));

    // R7 slow decay on comparator
    cmpHigh = 1'b1;
    tick(10);
    chk("R7 slow decay", gv(), slowPat());

    // R3 base period
    tick(300);
    measure("R3 period", 4, BASE, BASE);
    // R4 doubled frequency
    dblFreq = 1'b1;
    tick(400);
    measure("R4 halved period", 4, DBL, DBL);
    // R5 jitter
    jitterEn = 1'b1;
    tick(300);
    measure("R5 jitter halved", 10, DBL, DBL + JMAX);
    dblFreq = 1'b0;
    tick(400);
    measure("R5 jitter", 10, BASE, BASE + JMAX);
    jitterEn = 1'b0;

    // R9 fast decay on target drop
    cmpHigh = 1'b0;
    tick(400);
    chk("R6 forward before drop", gv(), fwdPat(1'b0));
    tgtMag = 5'd10; cmpHigh = 1'b1;
    tick(12);
    chk("R9 fast decay on drop", gv(), fastPat(1'b0));
    tick(400);
    chk("R9 fast held across periods", gv(), fastPat(1'b0));
    // R10 fast ends on comparator low
    cmpHigh = 1'b0;
    tick(12);
    total++;
    if (gv() != slowPat() && gv() != fwdPat(1'b0)) begin
      bad++;
      $display("FAIL R10 actual=%b expected=%b or %b", gv(), slowPat(), fwdPat(1'b0));
    end
    tick(400);
    chk("R10 forward after fast", gv(), fwdPat(1'b0));

    // R8 increase never fast
    tgtMag = 5'd25; cmpHigh = 1'b1;
    begin
      int fastSeen;
      fastSeen = 0;
      for (int i = 0; i < 400; i++) begin
        tick(1);
        if (gv() == fastPat(1'b0)) fastSeen++;
      end
      chk("R8 no fast on increase", fastSeen, 0);
    end

    // R6 polarity reversal (monitor covers R11/R12)
    cmpHigh = 1'b0; tgtSign = 1'b1;
    tick(400);
    chk("R6 forward sign1", gv(), fwdPat(1'b1));
    tgtMag = 5'd5; cmpHigh = 1'b1;
    tick(12);
    chk("R9 fast sign1", gv(), fastPat(1'b1));
    cmpHigh = 1'b0;
    tick(400);
    chk("R10 forward sign1", gv(), fwdPat(1'b1));

    // R8 random comparator with non-decreasing targets
    for (int blk = 0; blk < 4; blk++) begin
      int fastSeen;
      logic s;
      s = blk[0];
      cmpHigh = 1'b0; tgtSign = s;
      dblFreq = blk[1]; jitterEn = $urandom % 2;
      tick(400);
      fastSeen = 0;
      for (int i = 0; i < 3000; i++) begin
        @(negedge clk);
        if (gv() == fastPat(s)) fastSeen++;
        cmpHigh = ($urandom % 3) != 0;
        if (($urandom % 50) == 0 && tgtMag < 5'd31) tgtMag = tgtMag + 5'd1;
      end
      chk("R8 random steady no fast", fastSeen, 0);
      tgtMag = 5'd3;
      cmpHigh = 1'b0;
      tick(400);
    end

    // R2 enable drop mid-drive: off one cycle later
    tgtSign = 1'b0; cmpHigh = 1'b0; dblFreq = 1'b0; jitterEn = 1'b0;
    tick(400);
    chk("R6 forward before disable", gv(), fwdPat(1'b0));
    motEn = 1'b0;
    tick(1);
    chk("R2 off next cycle", gv(), 0);
    tick(300);
    chk("R2 stays off", gv(), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule